// File: doc/BRIEF.md
# Stream Packet FIFO

This block is a single-clock buffer for a valid/ready data stream. Each beat carries a data word, a byte-enable mask, an end-of-packet marker and a sideband user field, and all four travel together through a power-of-two ring of entries. The head entry is shown on the output as soon as it is stored. There is no extra pipeline stage on the read side.

When `PACKET_MODE` is set, the output holds back until a whole packet is buffered. A packet is whole once a beat with the end marker has been accepted. A count of complete packets held in the buffer decides when the output may present data. One case needs care: a packet longer than the buffer would block the writer forever. To avoid this, a full buffer that holds no complete packet opens the output. The output then stays open until that oversized packet's end marker leaves, or until the buffer runs empty.

Occupancy is reported twice, once for the writer and once for the reader. It is also reported as four level flags. Two of them are fixed: one entry short of full, and exactly one entry stored. The other two compare the level against parameter thresholds. Reset is asynchronous and active-low.

Top module: `stream_pkt_fifo`

## Requirements
- R1: While `rst_n` is low, `in_ready` is 0. After reset the block shows `out_valid`=0, both counts 0, `almost_empty`=0, `almost_full`=0, `prog_empty`=1, `prog_full`=0 and `in_ready`=1.
- R2: Beats leave in the order they were accepted. Data, keep, last and user of each beat are unchanged. A presented beat stays stable while `out_ready` is low.
- R3: When the level equals `DEPTH`, `in_ready` is 0. A beat offered while full is not stored and does not change the level.
- R4: With `PACKET_MODE`=1, `out_valid` stays 0 while no complete packet is stored. It becomes 1 in the cycle after the clock edge that accepts a beat with `in_last`=1.
- R5: The packet count goes up on each accepted beat with last=1 and down on each delivered beat with last=1. Once the final stored packet has been read, `out_valid` returns to 0, even if beats of a later, unfinished packet remain.
- R6: A full buffer with no complete packet raises `out_valid`. The output stays open while that data drains, until a last beat is delivered or the level reaches 0. After that, new incomplete data is withheld again.
- R7: `wr_count` and `rd_count` both equal the number of stored beats. Each changes on the clock edge of a handshake: +1 for a write alone, −1 for a read alone, unchanged for both together.
- R8: `almost_full` is 1 exactly when the level is `DEPTH`−1. `almost_empty` is 1 exactly when the level is 1.
- R9: `prog_full` is 1 when the level is at least `PROG_FULL_TH`. `prog_empty` is 1 when the level is at most `PROG_EMPTY_TH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Write beat offered |
| in_ready | output | 1 | Write beat can be taken |
| in_data | input | DATA_W | Write data |
| in_keep | input | DATA_W/8 | Write byte enables |
| in_last | input | 1 | Write beat ends a packet |
| in_user | input | USER_W | Write sideband |
| out_valid | output | 1 | Read beat presented |
| out_ready | input | 1 | Reader takes the beat |
| out_data | output | DATA_W | Read data |
| out_keep | output | DATA_W/8 | Read byte enables |
| out_last | output | 1 | Read beat ends a packet |
| out_user | output | USER_W | Read sideband |
| wr_count | output | $clog2(DEPTH)+1 | Level seen by the writer |
| rd_count | output | $clog2(DEPTH)+1 | Level seen by the reader |
| almost_full | output | 1 | One free entry left |
| almost_empty | output | 1 | One entry stored |
| prog_full | output | 1 | Level at or above the full threshold |
| prog_empty | output | 1 | Level at or below the empty threshold |

## Verification
A beat accepted at a clock edge shows up in the counts and flags right after that edge, with no further delay. A packet-closing write therefore opens the output in the same cycle, and a read retires the head entry at the edge it is taken. The bench changes inputs just after a rising edge and samples every output at the following falling edge. Each check sees the state produced by exactly the edges counted, and a scoreboard queue is filled and drained at those same falling-edge samples of the handshakes.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef struct packed {
        logic almost_full;
        logic almost_empty;
        logic prog_full;
        logic prog_empty;
    } spf_flags_t;

endpackage

// File: rtl/spf_store.sv
module spf_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 40,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_word;
        end
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl #(
    parameter int DEPTH       = 16,
    parameter bit PACKET_MODE = 1'b1,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          push_last,
    input  logic          pop_ready,
    input  logic          pop_last,
    output logic          push_ready,
    output logic          pop_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] level;
        logic [CW-1:0] pkts;
        logic          drain;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic is_full;
    logic is_empty;
    logic gate_open;
    logic do_wr;
    logic do_rd;

    assign is_full  = (st_q.level == CW'(DEPTH));
    assign is_empty = (st_q.level == '0);

    generate
        if (PACKET_MODE) begin : g_gate_pkt
            assign gate_open = (st_q.pkts != '0) || st_q.drain || is_full;
        end else begin : g_gate_none
            assign gate_open = 1'b1;
        end
    endgenerate

    assign push_ready = rst_n && !is_full;
    assign pop_valid  = !is_empty && gate_open;
    assign do_wr      = push_valid && push_ready;
    assign do_rd      = pop_valid && pop_ready;

    always_comb begin
        st_d = st_q;
        if (do_wr) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (do_rd) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        st_d.level = st_q.level + CW'(do_wr) - CW'(do_rd);
        st_d.pkts  = st_q.pkts + CW'(do_wr && push_last) - CW'(do_rd && pop_last);
        if (is_full && (st_q.pkts == '0)) begin
            st_d.drain = 1'b1;
        end else if ((do_rd && pop_last) || (st_d.level == '0)) begin
            st_d.drain = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = do_wr;
    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign level  = st_q.level;

endmodule

// File: rtl/spf_flags.sv
module spf_flags
    import spf_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int PROG_FULL_TH  = 12,
    parameter int PROG_EMPTY_TH = 3,
    localparam int CW           = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] level,
    output spf_flags_t    flags
);

    always_comb begin
        flags.almost_full  = (level == CW'(DEPTH - 1));
        flags.almost_empty = (level == CW'(1));
        flags.prog_full    = (level >= CW'(PROG_FULL_TH));
        flags.prog_empty   = (level <= CW'(PROG_EMPTY_TH));
    end

endmodule

// File: rtl/stream_pkt_fifo.sv
module stream_pkt_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int DATA_W        = 32,
    parameter int USER_W        = 4,
    parameter bit PACKET_MODE   = 1'b1,
    parameter int PROG_FULL_TH  = 12,
    parameter int PROG_EMPTY_TH = 3,
    localparam int KEEP_W       = DATA_W / 8,
    localparam int AW           = $clog2(DEPTH),
    localparam int CW           = AW + 1,
    localparam int WORD_W       = DATA_W + KEEP_W + 1 + USER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [KEEP_W-1:0] in_keep,
    input  logic              in_last,
    input  logic [USER_W-1:0] in_user,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [KEEP_W-1:0] out_keep,
    output logic              out_last,
    output logic [USER_W-1:0] out_user,
    output logic [CW-1:0]     wr_count,
    output logic [CW-1:0]     rd_count,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              prog_full,
    output logic              prog_empty
);

    generate
        if ((DEPTH < 16) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
            $error("DEPTH must be a power of two of at least 16");
        end
    endgenerate

    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic              wr_en;
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     level;
    spf_flags_t        flags;

    assign wr_word = {in_user, in_last, in_keep, in_data};
    assign {out_user, out_last, out_keep, out_data} = rd_word;

    spf_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_word (wr_word),
        .rd_addr (rd_ptr),
        .rd_word (rd_word)
    );

    spf_ctrl #(
        .DEPTH       (DEPTH),
        .PACKET_MODE (PACKET_MODE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_last  (in_last),
        .pop_ready  (out_ready),
        .pop_last   (rd_word[DATA_W + KEEP_W]),
        .push_ready (in_ready),
        .pop_valid  (out_valid),
        .wr_en      (wr_en),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .level      (level)
    );

    spf_flags #(
        .DEPTH         (DEPTH),
        .PROG_FULL_TH  (PROG_FULL_TH),
        .PROG_EMPTY_TH (PROG_EMPTY_TH)
    ) u_flags (
        .level (level),
        .flags (flags)
    );

    assign wr_count     = level;
    assign rd_count     = level;
    assign almost_full  = flags.almost_full;
    assign almost_empty = flags.almost_empty;
    assign prog_full    = flags.prog_full;
    assign prog_empty   = flags.prog_empty;

endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
    parameter int DEPTH         = 16,
    parameter int DATA_W        = 32,
    parameter int USER_W        = 4,
    parameter int PROG_FULL_TH  = 12,
    parameter int PROG_EMPTY_TH = 3,
    localparam int KEEP_W       = DATA_W / 8,
    localparam int CW           = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic [KEEP_W-1:0] in_keep,
    input logic              in_last,
    input logic [USER_W-1:0] in_user,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [KEEP_W-1:0] out_keep,
    input logic              out_last,
    input logic [USER_W-1:0] out_user,
    input logic [CW-1:0]     wr_count,
    input logic [CW-1:0]     rd_count,
    input logic              almost_full,
    input logic              almost_empty,
    input logic              prog_full,
    input logic              prog_empty
);

    AST_RESET_READY: assert property (@(posedge clk) !rst_n |-> !in_ready); // R1

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count == CW'(DEPTH)) |-> !in_ready); // R3

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_count == CW'(DEPTH)) && !(out_valid && out_ready)) |=> (wr_count == CW'(DEPTH))); // R3

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count == '0) |-> !out_valid); // R4

    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count == CW'(DEPTH)) |-> out_valid); // R6

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count == rd_count); // R7

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(out_valid && out_ready)) |=> (wr_count == $past(wr_count) + 1'b1)); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready) && out_valid && out_ready) |=> (wr_count == $past(wr_count) - 1'b1)); // R7

    AST_ALMOST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        almost_full == (wr_count == CW'(DEPTH - 1))); // R8

    AST_PROG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        prog_full == (wr_count >= CW'(PROG_FULL_TH))); // R9

endmodule

bind stream_pkt_fifo spf_checker #(
    .DEPTH         (DEPTH),
    .DATA_W        (DATA_W),
    .USER_W        (USER_W),
    .PROG_FULL_TH  (PROG_FULL_TH),
    .PROG_EMPTY_TH (PROG_EMPTY_TH)
) u_chk (.*);

// File: tb/stream_pkt_fifo_tb.sv
`timescale 1ns/1ps
module stream_pkt_fifo_tb;

    localparam int DEPTH  = 16;
    localparam int DATA_W = 32;
    localparam int USER_W = 4;
    localparam int PF_TH  = 12;
    localparam int PE_TH  = 3;
    localparam int KEEP_W = DATA_W / 8;
    localparam int CW     = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              in_valid, in_ready, in_last;
    logic [DATA_W-1:0] in_data;
    logic [KEEP_W-1:0] in_keep;
    logic [USER_W-1:0] in_user;
    logic              out_valid, out_ready, out_last;
    logic [DATA_W-1:0] out_data;
    logic [KEEP_W-1:0] out_keep;
    logic [USER_W-1:0] out_user;
    logic [CW-1:0]     wr_count, rd_count;
    logic              almost_full, almost_empty, prog_full, prog_empty;

    stream_pkt_fifo #(
        .DEPTH (DEPTH), .DATA_W (DATA_W), .USER_W (USER_W), .PACKET_MODE (1'b1),
        .PROG_FULL_TH (PF_TH), .PROG_EMPTY_TH (PE_TH)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .in_keep (in_keep), .in_last (in_last), .in_user (in_user),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_keep (out_keep), .out_last (out_last), .out_user (out_user),
        .wr_count (wr_count), .rd_count (rd_count),
        .almost_full (almost_full), .almost_empty (almost_empty),
        .prog_full (prog_full), .prog_empty (prog_empty)
    );

    typedef struct packed {
        logic [USER_W-1:0] user;
        logic              last;
        logic [KEEP_W-1:0] keep;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t expq [$];
    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard: logs writes, compares reads, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) begin
                expq.push_back('{user: in_user, last: in_last, keep: in_keep, data: in_data});
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2", "read with nothing expected", 1, 0);
                end else begin
                    beat_t e;
                    beat_t a;
                    e = expq.pop_front();
                    a = '{user: out_user, last: out_last, keep: out_keep, data: out_data};
                    check(a == e, "R2", "beat content/order", longint'(a.data), longint'(e.data));
                end
            end
        end
    end

    task automatic put(input int v, input bit last);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = DATA_W'(v);
        in_keep  = KEEP_W'(v * 3);
        in_user  = USER_W'(v + 1);
        in_last  = last;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic take_one();
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(negedge clk);
        while (wr_count != '0) @(negedge clk);
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic expect_level(input int n);
        check(wr_count == CW'(n), "R7", "wr_count", wr_count, n);
        check(rd_count == CW'(n), "R7", "rd_count", rd_count, n);
        check(almost_full == (n == DEPTH - 1), "R8", "almost_full", almost_full, n == DEPTH - 1);
        check(almost_empty == (n == 1), "R8", "almost_empty", almost_empty, n == 1);
        check(prog_full == (n >= PF_TH), "R9", "prog_full", prog_full, n >= PF_TH);
        check(prog_empty == (n <= PE_TH), "R9", "prog_empty", prog_empty, n <= PE_TH);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_last = 1'b0;
        in_data = '0; in_keep = '0; in_user = '0;
        @(negedge clk);
        check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        rst_n = 1'b1;
        settle();
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        expect_level(0);

        // R4: gating until the last beat
        for (int i = 0; i < 3; i++) put(i, 1'b0);
        settle();
        check(out_valid == 1'b0, "R4", "out_valid before last", out_valid, 0);
        expect_level(3);
        put(3, 1'b1);
        settle();
        check(out_valid == 1'b1, "R4", "out_valid after last", out_valid, 1);
        drain();
        settle();
        check(out_valid == 1'b0, "R4", "out_valid when empty", out_valid, 0);

        // R5: one full packet then a partial one
        put(10, 1'b0); put(11, 1'b1); put(12, 1'b0); put(13, 1'b0);
        take_one(); take_one();
        settle();
        check(out_valid == 1'b0, "R5", "out_valid with partial left", out_valid, 0);
        check(wr_count == CW'(2), "R5", "level with partial left", wr_count, 2);
        put(14, 1'b1);
        settle();
        check(out_valid == 1'b1, "R5", "out_valid after closing", out_valid, 1);
        drain();

        // R3 R6 R8 R9: fill without any last beat
        for (int i = 0; i < DEPTH; i++) begin
            put(100 + i, 1'b0);
            settle();
            expect_level(i + 1);
            if (i + 1 < DEPTH)
                check(out_valid == 1'b0, "R6", "gated while not full", out_valid, 0);
        end
        check(in_ready == 1'b0, "R3", "in_ready when full", in_ready, 0);
        check(out_valid == 1'b1, "R6", "release when full", out_valid, 1);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = DATA_W'(999); in_last = 1'b1;
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        settle();
        check(wr_count == CW'(DEPTH), "R3", "level after overflow try", wr_count, DEPTH);
        for (int i = 0; i < DEPTH / 2; i++) take_one();
        settle();
        check(out_valid == 1'b1, "R6", "drain stays open", out_valid, 1);
        check(wr_count == CW'(DEPTH / 2), "R6", "level mid drain", wr_count, DEPTH / 2);
        drain();
        put(200, 1'b0);
        settle();
        check(out_valid == 1'b0, "R6", "gate restored after drain", out_valid, 0);
        put(201, 1'b1);
        drain();

        // R7: write and read in the same cycle
        put(300, 1'b1); put(301, 1'b0); put(302, 1'b1);
        settle();
        expect_level(3);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = DATA_W'(303); in_keep = '1; in_user = '0; in_last = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        check(in_ready && out_valid, "R7", "both handshakes offered", in_ready && out_valid, 1);
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 1'b0;
        settle();
        check(wr_count == CW'(3), "R7", "level after simultaneous", wr_count, 3);
        drain();
        settle();

        check(expq.size() == 0, "R2", "scoreboard left", expq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule